// File: doc/BRIEF.md
# Byte-or-Word Parallel DAC Code Loader

This block is the parallel-bus front end of a four-channel, 14-bit voltage converter. A host drives a channel address, a data word, a chip select and a write strobe. On the rising edge of the strobe, with chip select low, the addressed channel's input register takes new data. In word mode, all 14 bits land in one write. In byte mode, the code is right-justified and assembled from two writes: an 8-bit lower part and a 6-bit upper part. A byte-shift select picks which part a given write fills.

Each input register feeds an output latch, and the latches drive the converter codes. The input registers and the latches form a double buffer. New codes can be staged in the input registers without disturbing the outputs. An active-low load control, qualified by a per-channel mask, then copies the staged codes into any set of latches at one clock edge. That set can be all four latches at once or a single one. An asynchronous active-low clear forces every latch to the clear code at once. The clear leaves the staged input values untouched. All control inputs are taken as synchronous to `clk`, except the two resets.

Top module: `dac_byte_word_loader`

## Requirements
- R1: After reset, every input register and every output latch holds the clear code 14'h2000. A load issued before any write therefore leaves every output at 14'h2000.
- R2: With `byte_mode` = 0, a captured write copies `data[13:0]` into all 14 bits of the addressed channel's input register.
- R3: With `byte_mode` = 1 and `byte_sel` = 1, a captured write copies `data[7:0]` into code bits 7..0. Code bits 13..8 and `data[13:8]` have no effect on the result.
- R4: With `byte_mode` = 1 and `byte_sel` = 0, a captured write copies `data[5:0]` into code bits 13..8. Code bits 7..0 keep their value.
- R5: The two parts may be written in either order, and each may be rewritten. A load always uses the most recent value of each part.
- R6: A write is captured only at the clock edge where `wr_n` is first seen high after being low, and only if `cs_n` is low at that edge. A strobe rise with `cs_n` high writes nothing.
- R7: Channel addresses 0 to 3 select channels 0 to 3. A write to any address of 4 or above changes no input register.
- R8: While `ldac_n` is low at a clock edge, every channel whose `ld_mask` bit is 1 copies its input register into its output latch. Channels whose bit is 0 keep their value.
- R9: While `ldac_n` is high, the outputs keep their values, whatever writes reach the input registers.
- R10: While `clr_n` is low, all outputs equal the clear code. This takes effect without waiting for a clock edge. The outputs stay at the clear code after `clr_n` rises, until the next load. The input registers keep their contents throughout.
- R11: When a write and a load of the same channel fall on the same clock edge, the latch receives the input register's value from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all synchronous logic |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| cs_n | input | 1 | Active-low chip select that qualifies a write |
| wr_n | input | 1 | Active-low write strobe; data is captured on its rise |
| byte_mode | input | 1 | 0: 14-bit word writes; 1: two-part byte writes |
| byte_sel | input | 1 | Byte mode only. 1: lower 8 bits; 0: upper 6 bits |
| addr | input | 3 | Channel address; only 0 to 3 are valid |
| data | input | 14 | Parallel data bus |
| ldac_n | input | 1 | Active-low load of the input registers into the latches |
| ld_mask | input | 4 | Per-channel enable for a load |
| clr_n | input | 1 | Asynchronous active-low clear of the output latches |
| dac_codes | output | 56 | Latched codes; channel i occupies bits 14*i+13 to 14*i |

## Verification
Some properties are checked by assertions on every cycle. A cycle without a captured write leaves the input registers unchanged, and so does a write to an invalid address. A masked load copies staged codes into the latches, and a full-width write stores the bus word. The outputs hold while no load is pending, and an active clear holds them at the clear code. Other behaviour shows only through the bench's scenarios: two-part assembly in both orders, with rewrites and with ignored upper data lines. The same goes for the clear code appearing between clock edges and staged values surviving a clear. The last is the ordering between a write and a load that meet at one edge. A behavioural reference model, updated every clock, compares all four outputs throughout.

// File: rtl/dacld_pkg.sv
package dacld_pkg;

    // Kind of update a captured bus write applies to an input register
    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_FULL = 2'd1,
        WK_LOW  = 2'd2,
        WK_HIGH = 2'd3
    } wr_kind_e;

endpackage

// File: rtl/dacld_wr_decode.sv
module dacld_wr_decode
    import dacld_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              cs_n,
    input  logic              byte_mode,
    input  logic              byte_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_CH-1:0]   ch_we,
    output wr_kind_e          kind
);

    localparam logic [ADDR_W:0] CH_LIMIT = (ADDR_W+1)'(N_CH);

    typedef struct packed {
        logic wr_q;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic    strobe_rise;
    logic    addr_ok;
    logic    fire;

    always_comb begin
        st_d        = st_q;
        st_d.wr_q   = wr_n;
        strobe_rise = wr_n & ~st_q.wr_q;
        addr_ok     = ({1'b0, addr} < CH_LIMIT);
        fire        = strobe_rise & ~cs_n & addr_ok;
        if (!fire)
            kind = WK_NONE;
        else if (!byte_mode)
            kind = WK_FULL;
        else if (byte_sel)
            kind = WK_LOW;
        else
            kind = WK_HIGH;
    end

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_sel
            assign ch_we[i] = fire && (addr == ADDR_W'(i));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{wr_q: 1'b1};
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/dacld_input_bank.sv
module dacld_input_bank
    import dacld_pkg::*;
#(
    parameter int                 N_CH     = 4,
    parameter int                 CODE_W   = 14,
    parameter int                 LO_W     = 8,
    parameter logic [CODE_W-1:0]  CLR_CODE = 14'h2000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CH-1:0]          ch_we,
    input  wr_kind_e                 kind,
    input  logic [CODE_W-1:0]        data,
    output logic [N_CH*CODE_W-1:0]   codes
);

    localparam int HI_W = CODE_W - LO_W;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t [N_CH-1:0] ch;
    } bank_st_t;

    bank_st_t st_d, st_q;

    function automatic code_t merge_code(code_t cur, code_t din, wr_kind_e k);
        code_t res;
        case (k)
            WK_FULL: res = din;
            WK_LOW:  res = {cur[CODE_W-1:LO_W], din[LO_W-1:0]};
            WK_HIGH: res = {din[HI_W-1:0], cur[LO_W-1:0]};
            default: res = cur;
        endcase
        return res;
    endfunction

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_CH; i++) begin
            if (ch_we[i])
                st_d.ch[i] = merge_code(st_q.ch[i], data, kind);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= {N_CH{CLR_CODE}};
        else
            st_q <= st_d;
    end

    assign codes = st_q.ch;

endmodule

// File: rtl/dacld_out_latch.sv
module dacld_out_latch #(
    parameter int                 N_CH     = 4,
    parameter int                 CODE_W   = 14,
    parameter logic [CODE_W-1:0]  CLR_CODE = 14'h2000
) (
    input  logic                     clk,
    input  logic                     aclr_n,
    input  logic                     ld_n,
    input  logic [N_CH-1:0]          ld_mask,
    input  logic [N_CH*CODE_W-1:0]   in_codes,
    output logic [N_CH*CODE_W-1:0]   out_codes
);

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t [N_CH-1:0] ch;
    } lat_st_t;

    lat_st_t          st_d, st_q;
    code_t [N_CH-1:0] staged;

    assign staged = in_codes;

    always_comb begin
        st_d = st_q;
        if (!ld_n) begin
            for (int i = 0; i < N_CH; i++) begin
                if (ld_mask[i])
                    st_d.ch[i] = staged[i];
            end
        end
    end

    always_ff @(posedge clk or negedge aclr_n) begin
        if (!aclr_n)
            st_q <= {N_CH{CLR_CODE}};
        else
            st_q <= st_d;
    end

    assign out_codes = st_q.ch;

endmodule

// File: rtl/dac_byte_word_loader.sv
module dac_byte_word_loader
    import dacld_pkg::*;
#(
    parameter int                 N_CH     = 4,
    parameter int                 CODE_W   = 14,
    parameter int                 LO_W     = 8,
    parameter int                 ADDR_W   = 3,
    parameter logic [CODE_W-1:0]  CLR_CODE = 14'h2000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     wr_n,
    input  logic                     byte_mode,
    input  logic                     byte_sel,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [CODE_W-1:0]        data,
    input  logic                     ldac_n,
    input  logic [N_CH-1:0]          ld_mask,
    input  logic                     clr_n,
    output logic [N_CH*CODE_W-1:0]   dac_codes
);

    logic [N_CH-1:0]        ch_we;
    wr_kind_e               kind;
    logic [N_CH*CODE_W-1:0] in_codes;
    logic                   aclr_n;

    // Output latches clear on either reset source
    assign aclr_n = rst_n & clr_n;

    dacld_wr_decode #(
        .N_CH   (N_CH),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_n      (wr_n),
        .cs_n      (cs_n),
        .byte_mode (byte_mode),
        .byte_sel  (byte_sel),
        .addr      (addr),
        .ch_we     (ch_we),
        .kind      (kind)
    );

    dacld_input_bank #(
        .N_CH     (N_CH),
        .CODE_W   (CODE_W),
        .LO_W     (LO_W),
        .CLR_CODE (CLR_CODE)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .ch_we (ch_we),
        .kind  (kind),
        .data  (data),
        .codes (in_codes)
    );

    dacld_out_latch #(
        .N_CH     (N_CH),
        .CODE_W   (CODE_W),
        .CLR_CODE (CLR_CODE)
    ) u_lat (
        .clk       (clk),
        .aclr_n    (aclr_n),
        .ld_n      (ldac_n),
        .ld_mask   (ld_mask),
        .in_codes  (in_codes),
        .out_codes (dac_codes)
    );

endmodule

// File: rtl/dacld_checker.sv
module dacld_checker #(
    parameter int                 N_CH     = 4,
    parameter int                 CODE_W   = 14,
    parameter int                 ADDR_W   = 3,
    parameter logic [CODE_W-1:0]  CLR_CODE = 14'h2000
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_n,
    input logic                     wr_n,
    input logic                     byte_mode,
    input logic [ADDR_W-1:0]        addr,
    input logic [CODE_W-1:0]        data,
    input logic                     ldac_n,
    input logic [N_CH-1:0]          ld_mask,
    input logic                     clr_n,
    input logic [N_CH*CODE_W-1:0]   in_codes,
    input logic [N_CH*CODE_W-1:0]   dac_codes
);

    localparam logic [ADDR_W:0] CH_LIMIT = (ADDR_W+1)'(N_CH);

    // R6: without a strobe rise under chip select the staged codes hold
    assert_no_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_n && !$past(wr_n) && !cs_n) |=> $stable(in_codes));

    // R7: invalid channel addresses never alter staged codes
    assert_bad_addr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, addr} >= CH_LIMIT) |=> $stable(in_codes));

    // R9: outputs hold while no load is requested
    assert_hold_no_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_n && clr_n) |=> (!clr_n || $stable(dac_codes)));

    // R10: an active clear shows the clear code on every channel
    assert_clear_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (dac_codes == {N_CH{CLR_CODE}}));

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            // R2: a word write stores the whole bus value
            assert_word_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && wr_n && !$past(wr_n) && !cs_n && !byte_mode
                 && (addr == ADDR_W'(i)))
                |=> (in_codes[i*CODE_W +: CODE_W] == $past(data)));

            // R8: a masked load copies the staged code into the latch
            assert_masked_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (!ldac_n && ld_mask[i] && clr_n)
                |=> (!clr_n || dac_codes[i*CODE_W +: CODE_W]
                               == $past(in_codes[i*CODE_W +: CODE_W])));
        end
    endgenerate

endmodule

bind dac_byte_word_loader dacld_checker #(
    .N_CH     (N_CH),
    .CODE_W   (CODE_W),
    .ADDR_W   (ADDR_W),
    .CLR_CODE (CLR_CODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .byte_mode (byte_mode),
    .addr      (addr),
    .data      (data),
    .ldac_n    (ldac_n),
    .ld_mask   (ld_mask),
    .clr_n     (clr_n),
    .in_codes  (in_codes),
    .dac_codes (dac_codes)
);

// File: tb/tb_dac_byte_word_loader.sv
`timescale 1ns/100ps
module tb_dac_byte_word_loader;

    localparam int NC = 4;
    localparam int CW = 14;
    localparam int CLRV = 'h2000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          byte_mode = 1'b0;
    logic          byte_sel = 1'b0;
    logic [2:0]    addr = '0;
    logic [CW-1:0] data = '0;
    logic          ldac_n = 1'b1;
    logic [NC-1:0] ld_mask = '0;
    logic          clr_n = 1'b1;
    logic [NC*CW-1:0] dac_codes;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // Reference model state
    int m_in  [NC];
    int m_out [NC];
    bit m_wr_prev = 1'b1;

    always #2.5 clk = ~clk;

    dac_byte_word_loader dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .byte_mode(byte_mode), .byte_sel(byte_sel), .addr(addr),
        .data(data), .ldac_n(ldac_n), .ld_mask(ld_mask), .clr_n(clr_n),
        .dac_codes(dac_codes)
    );

    initial begin
        for (int c = 0; c < NC; c++) begin
            m_in[c]  = CLRV;
            m_out[c] = CLRV;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                m_in[c]  = CLRV;
                m_out[c] = CLRV;
            end
            m_wr_prev = 1'b1;
        end else begin
            for (int c = 0; c < NC; c++) begin
                if (!clr_n)
                    m_out[c] = CLRV;
                else if (!ldac_n && ld_mask[c])
                    m_out[c] = m_in[c];
            end
            if (wr_n && !m_wr_prev && !cs_n && int'(addr) < NC) begin
                if (!byte_mode)
                    m_in[addr] = int'(data);
                else if (byte_sel)
                    m_in[addr] = (m_in[addr] & 'h3F00) | (int'(data) & 'hFF);
                else
                    m_in[addr] = ((int'(data) & 'h3F) << 8) | (m_in[addr] & 'hFF);
            end
            m_wr_prev = wr_n;
        end
    end

    function automatic int out_of(int c);
        return int'(dac_codes[c*CW +: CW]);
    endfunction

    task automatic check_ch(int c, int exp, string req);
        checks++;
        if (out_of(c) !== exp) begin
            errors++;
            $display("FAIL %s ch%0d: actual %h expected %h", req, c, out_of(c), exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        for (int c = 0; c < NC; c++) check_ch(c, m_out[c], cur_req);
    endtask

    task automatic bus_write(int a, int d, bit bm, bit bs);
        addr = 3'(a); data = CW'(d); byte_mode = bm; byte_sel = bs;
        cs_n = 1'b0; wr_n = 1'b0;
        tick();
        wr_n = 1'b1;
        tick();
        cs_n = 1'b1;
    endtask

    task automatic load(logic [NC-1:0] m);
        ldac_n = 1'b0; ld_mask = m;
        tick();
        ldac_n = 1'b1; ld_mask = '0;
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state and load of untouched registers
        cur_req = "R1";
        for (int c = 0; c < NC; c++) check_ch(c, 'h2000, "R1");
        load(4'b1111);
        for (int c = 0; c < NC; c++) check_ch(c, 'h2000, "R1");

        // R2 word write, R9 hold before load, R8 load all
        cur_req = "R2";
        bus_write(0, 'h1ABC, 1'b0, 1'b0);
        check_ch(0, 'h2000, "R9");
        load(4'b1111);
        check_ch(0, 'h1ABC, "R2");
        check_ch(3, 'h2000, "R8");

        // R3 low part with junk upper lines, then R4 upper part
        cur_req = "R3";
        bus_write(1, 'h3F5A, 1'b1, 1'b1);
        load(4'b0010);
        check_ch(1, 'h205A, "R3");
        cur_req = "R4";
        bus_write(1, 'h3FE5, 1'b1, 1'b0);
        load(4'b0010);
        check_ch(1, 'h255A, "R4");

        // R5 upper first, then low written twice; R8 single-channel load
        cur_req = "R5";
        bus_write(2, 'h0011, 1'b1, 1'b0);
        bus_write(2, 'h0077, 1'b1, 1'b1);
        bus_write(2, 'h00C3, 1'b1, 1'b1);
        load(4'b0100);
        check_ch(2, 'h11C3, "R5");
        check_ch(1, 'h255A, "R8");
        check_ch(0, 'h1ABC, "R8");

        // R6 write with chip select high; strobe rise after deselect
        cur_req = "R6";
        addr = 3'd3; data = 14'h0555; byte_mode = 1'b0;
        cs_n = 1'b1; wr_n = 1'b0; tick(); wr_n = 1'b1; tick();
        cs_n = 1'b0; wr_n = 1'b0; tick(); tick();
        cs_n = 1'b1; tick(); wr_n = 1'b1; tick();
        load(4'b1111);
        check_ch(3, 'h2000, "R6");

        // R7 invalid addresses 4 and 5
        cur_req = "R7";
        bus_write(4, 'h0333, 1'b0, 1'b0);
        bus_write(5, 'h0444, 1'b0, 1'b0);
        load(4'b1111);
        check_ch(0, 'h1ABC, "R7");
        check_ch(1, 'h255A, "R7");
        check_ch(2, 'h11C3, "R7");
        check_ch(3, 'h2000, "R7");

        // R9 staged write stays off the outputs
        cur_req = "R9";
        bus_write(3, 'h0F0F, 1'b0, 1'b0);
        tick(); tick();
        check_ch(3, 'h2000, "R9");

        // R10 asynchronous clear, staged values survive
        cur_req = "R10";
        clr_n = 1'b0;
        #1;
        for (int c = 0; c < NC; c++) check_ch(c, 'h2000, "R10");
        tick();
        clr_n = 1'b1;
        tick();
        check_ch(0, 'h2000, "R10");
        load(4'b1111);
        check_ch(0, 'h1ABC, "R10");
        check_ch(1, 'h255A, "R10");
        check_ch(2, 'h11C3, "R10");
        check_ch(3, 'h0F0F, "R10");

        // R11 write and load meeting at one edge
        cur_req = "R11";
        addr = 3'd0; data = 14'h0001; byte_mode = 1'b0;
        cs_n = 1'b0; wr_n = 1'b0; tick();
        wr_n = 1'b1; ldac_n = 1'b0; ld_mask = 4'b0001; tick();
        cs_n = 1'b1; ldac_n = 1'b1; ld_mask = '0;
        check_ch(0, 'h1ABC, "R11");
        load(4'b0001);
        check_ch(0, 'h0001, "R11");

        tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule